// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block sequences a successive-approximation analog-to-digital conversion. It drives the code of an external binary DAC and reads back one comparator bit. That bit is 1 when the analog input is strictly above the voltage the DAC is producing. A start request launches a binary search. The search works down from the most significant code bit to the least significant one and settles one bit in every clock cycle. Its result is the highest code whose DAC level lies below the input, so the next code up is the first level at or above the input.

The code width `W` is a parameter with a default of 4. Each bit trial sets the bit under test to 1 and all lower bits to 0. Higher bits keep the values already decided. When the last bit is settled, the finished code is registered and a one-cycle completion strobe is raised. A new request can be accepted in that same cycle, so conversions can run back to back. The logic grows linearly with `W`: one pointer bit and one code bit per resolution bit.

Top module: `sar_adc_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `dac_code`, `result`, `busy` and `done` are all 0.
- R2: A `start` sampled high while `busy` is low makes `busy` 1 in the next cycle. In that cycle `dac_code` holds only its most significant bit set (8 for W=4).
- R3: For every trial after the first, `dac_code` keeps the previously decided upper bits, sets the next lower bit to 1 and has all bits below it at 0.
- R4: When a trial code is on `dac_code`, a `cmp_above` of 1 keeps the bit under test and a 0 clears it. An input exactly equal to the trial level counts as not above.
- R5: `busy` stays high for exactly W cycles per conversion. `done` is high for exactly one cycle, the cycle right after the least significant trial. `busy` is low in that cycle.
- R6: `result` takes the final decided code in the cycle `done` is high. It holds that value until the next `done`.
- R7: A `start` sampled while `busy` is high is ignored: the trial sequence and the completion timing of the running conversion do not change, and no new conversion follows it.
- R8: A `start` sampled in the cycle `done` is high begins a new conversion at once.
- R9: With W=4, 0.5 V per code step and a 5.25 V input, the trial codes are 8, 12, 10, 11 and the result is 10.
- R10: Whenever `busy` is low, `dac_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Conversion request, sampled on the clock |
| cmp_above | input | 1 | 1 when the analog input is strictly above the current DAC level |
| dac_code | output | W | Trial code driven to the DAC |
| busy | output | 1 | High while bit trials are in progress |
| result | output | W | Last completed conversion code |
| done | output | 1 | One-cycle strobe marking a new `result` |

## Verification
A wrong pointer or a wrong code bit shows on `dac_code` in the very next trial cycle. The bench compares every trial against a search it computes from an ideal millivolt threshold model, so such an error is caught within one cycle of its cause. Errors in the sequencing show up as `done` arriving early or late, or lasting more than one cycle. They also show up as `busy` failing to drop, or as a request made while busy leaving a stray conversion. The bench checks all of these on the cycle they should happen. Inputs that sit exactly on a code level probe the strict comparison, and inputs at both ends of the range probe the all-zero and all-one results.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Default resolution of the conversion in bits.
  localparam int unsigned SAR_DEFAULT_W = 4;

  // Code with only the top bit of a w-bit field set (upper bound 32 bits).
  function automatic logic [31:0] top_bit(input int unsigned w);
    return 32'd1 << (w - 1);
  endfunction
endpackage

// File: rtl/sar_bit_ptr.sv
// One-hot pointer that walks from the top code bit to bit 0.
module sar_bit_ptr #(
  parameter int unsigned W = sar_pkg::SAR_DEFAULT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic [W-1:0] ptr,
  output logic         busy,
  output logic         launch,
  output logic         last
);
  localparam logic [W-1:0] FIRST = W'(sar_pkg::top_bit(W));

  assign busy   = |ptr;
  assign launch = start & ~busy;
  assign last   = ptr[0];

  always_ff @(posedge clk) begin
    if (rst)         ptr <= '0;
    else if (launch) ptr <= FIRST;
    else             ptr <= ptr >> 1;
  end
endmodule

// File: rtl/sar_trial_reg.sv
// Trial code register: settles the pointed bit and sets up the next trial.
module sar_trial_reg #(
  parameter int unsigned W = sar_pkg::SAR_DEFAULT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         launch,
  input  logic         last,
  input  logic [W-1:0] ptr,
  input  logic         cmp_above,
  output logic [W-1:0] code,
  output logic [W-1:0] decided
);
  localparam logic [W-1:0] FIRST = W'(sar_pkg::top_bit(W));

  // The bit under test survives only if the input is above its level.
  assign decided = cmp_above ? code : (code & ~ptr);

  always_ff @(posedge clk) begin
    if (rst)          code <= '0;
    else if (launch)  code <= FIRST;
    else if (last)    code <= '0;
    else if (|ptr)    code <= decided | (ptr >> 1);
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int unsigned W = sar_pkg::SAR_DEFAULT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         cmp_above,
  output logic [W-1:0] dac_code,
  output logic         busy,
  output logic [W-1:0] result,
  output logic         done
);
  logic [W-1:0] ptr;
  logic [W-1:0] decided;
  logic         launch;
  logic         last;

  sar_bit_ptr #(.W(W)) u_ptr (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .ptr    (ptr),
    .busy   (busy),
    .launch (launch),
    .last   (last)
  );

  sar_trial_reg #(.W(W)) u_trial (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .last      (last),
    .ptr       (ptr),
    .cmp_above (cmp_above),
    .code      (dac_code),
    .decided   (decided)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (last) result <= decided;
    end
  end
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         cmp_above,
  input logic [W-1:0] dac_code,
  input logic         busy,
  input logic [W-1:0] result,
  input logic         done
);
  localparam logic [W-1:0] FIRST = W'(1) << (W - 1);

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && dac_code == FIRST));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10
  idle_code_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> dac_code == '0);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

  // R3
  trial_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> dac_code != '0);
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .cmp_above (cmp_above),
  .dac_code  (dac_code),
  .busy      (busy),
  .result    (result),
  .done      (done)
);

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;
  localparam int W       = 4;
  localparam int STEP_MV = 500;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         cmp_above;
  logic [W-1:0] dac_code;
  logic         busy;
  logic [W-1:0] result;
  logic         done;
  int           vin_mv = 0;
  int           checks = 0;
  int           errors = 0;
  bit           finished = 1'b0;

  always #10 clk = ~clk;

  // Ideal DAC plus comparator: strictly above the level means 1.
  assign cmp_above = (vin_mv > int'(dac_code) * STEP_MV);

  sar_adc_ctrl #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cmp_above(cmp_above),
    .dac_code(dac_code), .busy(busy), .result(result), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected trial codes and final code from the search rules (R3, R4).
  task automatic expect_search(input int mv, output int tr[W], output int fin);
    int c = 0;
    for (int b = W - 1; b >= 0; b--) begin
      int t = c | (1 << b);
      tr[W - 1 - b] = t;
      if (mv > t * STEP_MV) c = t;
    end
    fin = c;
  endtask

  // Called at a falling edge with start already raised for one cycle.
  // Walks the trials, checks each, and stops on the done cycle.
  task automatic follow(input int mv, input string tag, input bit poke_mid, input bit chain);
    int tr[W];
    int fin;
    expect_search(mv, tr, fin);
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < W; i++) begin
      check(busy == 1'b1, {tag, " R5 busy"}, int'(busy), 1);
      check(int'(dac_code) == tr[i], {tag, " R3 trial"}, int'(dac_code), tr[i]);
      check(done == 1'b0, {tag, " R5 no early done"}, int'(done), 0);
      if (poke_mid && i == 1) start = 1'b1;   // R7 request while busy
      @(negedge clk);
      start = 1'b0;
    end
    check(done == 1'b1, {tag, " R5 done"}, int'(done), 1);
    check(busy == 1'b0, {tag, " R5 idle at done"}, int'(busy), 0);
    check(int'(result) == fin, {tag, " R6 R4 result"}, int'(result), fin);
    check(dac_code == '0, {tag, " R10 idle code"}, int'(dac_code), 0);
    if (chain) start = 1'b1;
  endtask

  task automatic run_one(input int mv, input string tag);
    vin_mv = mv;
    start = 1'b1;
    follow(mv, tag, 1'b0, 1'b0);
    @(negedge clk);
    check(done == 1'b0, {tag, " R5 single pulse"}, int'(done), 1'b0);
  endtask

  task automatic t_reset;
    check(dac_code == '0 && result == '0 && !busy && !done, "R1 reset",
          int'({busy, done, dac_code, result}), 0);
  endtask

  task automatic t_example;
    int tr[W];
    int fin;
    expect_search(5250, tr, fin);
    check(tr[0] == 8 && tr[1] == 12 && tr[2] == 10 && tr[3] == 11 && fin == 10,
          "R9 model", fin, 10);
    vin_mv = 5250;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && dac_code == 4'd8, "R2 R9 first trial", int'(dac_code), 8);
    @(negedge clk); check(dac_code == 4'd12, "R9 trial 2", int'(dac_code), 12);
    @(negedge clk); check(dac_code == 4'd10, "R9 trial 3", int'(dac_code), 10);
    @(negedge clk); check(dac_code == 4'd11, "R9 trial 4", int'(dac_code), 11);
    @(negedge clk);
    check(done && result == 4'd10, "R9 result", int'(result), 10);
    @(negedge clk);
    check(!done && result == 4'd10, "R6 hold", int'(result), 10);
  endtask

  task automatic t_ignore_busy;
    vin_mv = 3700;
    start = 1'b1;
    follow(3700, "busy-start", 1'b1, 1'b0);
    @(negedge clk);
    check(busy == 1'b0, "R7 no extra conversion", int'(busy), 0);
    check(int'(result) == 7, "R7 result kept", int'(result), 7);
  endtask

  task automatic t_back_to_back;
    vin_mv = 1200;
    start = 1'b1;
    follow(1200, "chain A", 1'b0, 1'b1);
    vin_mv = 6900;
    follow(6900, "chain B R8", 1'b0, 1'b0);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R8 end", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_example();
    run_one(0, "zero");
    run_one(7499, "top");
    run_one(2500, "equal R4");
    run_one(9000, "over range");
    t_ignore_busy();
    t_back_to_back();
    repeat (2) @(negedge clk);
    check(dac_code == '0 && !busy, "R10 idle", int'(dac_code), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule